// File: doc/BRIEF.md
# Convolution Forward Loop Sequencer

This block is a finite-state controller that evaluates the forward pass of a 2-D convolution layer. The input, filter, bias and output tensors all live in an external word-addressed memory. A start pulse arrives with the layer geometry on the configuration ports: stride, pad, output height and width, output and input channel counts, kernel height and width, and input height and width. The same pulse carries four region base addresses. The controller then walks the nested loops, forms every address itself, and accumulates signed 32-bit products into the output words. It adds the per-channel bias at the end of each output pixel.

All memory traffic uses one serialized request port. A request is held until the memory answers with a one-cycle done pulse. Each inner step loads three operands in turn: the current output word, the filter tap and the input sample. It multiplies the filter tap by the input sample, adds the product to the output word and writes the result back. Input taps that land in the padding border read as zero and cost no memory access.

The loop order is fixed. Output column is outermost, then output row, kernel column, kernel row and input channel. Output channel is innermost. Before touching any tensor data, the block writes a two-word shape header to the start of the output region.

Top module: `conv_fwd_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are all low.
- R2: `start` is honoured only while idle. A pulse during a run changes neither the results nor the number of `done` pulses.
- R3: The configuration ports are captured during the four cycles after `start` and must hold steady for those cycles. The first two writes are output height to `out_base` and then output width to `out_base+1`.
- R4: Each output z[d,i,j] lives at word `out_base+2+d+Cout*(i+Hout*j)`. It ends as its previous value plus the sum of f*x over all kernel taps and input channels, plus b[d], in wrapping signed 32-bit arithmetic. The filter word is at `filt_base+d+Cout*(g+Cin*(a+Kh*b))`, the input word at `in_base+g+Cin*r+Hin*Cin*c`, and the bias at `bias_base+d`.
- R5: A tap is in the padding border when its row r falls outside 0..Hin-1 or its column c outside 0..Win-1. Such a tap contributes zero and issues no read. Every in-range tap is read once per output channel.
- R6: While `mem_req` is high and `mem_done` has not arrived, the request stays high and its address, direction and write data stay unchanged. Only one access is outstanding at a time.
- R7: `busy` is high from the cycle after an accepted `start` until the final cycle of the run. In that final cycle `done` is high for exactly one cycle with `busy` low, and the block then returns to idle.
- R8: For output column j and row i, the tap coordinates are c = j*stride - pad + b and r = i*stride - pad + a. The starting offsets are the two's-complement negative of pad, and each advances by stride.
- R9: The bias is added exactly once per output element. This happens in a pass that follows all kernel taps of that pixel.
- R10: Writes touch only the output region. Their total is 2 + Hout*Wout*Cout*(Kh*Kw*Cin+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a layer pass (idle only) |
| cfg_stride | input | NW | Step between output positions |
| cfg_pad | input | NW | Zero border width |
| cfg_out_h | input | NW | Output rows |
| cfg_out_w | input | NW | Output columns |
| cfg_out_ch | input | NW | Output channels |
| cfg_in_ch | input | NW | Input channels |
| cfg_k_h | input | NW | Kernel rows |
| cfg_k_w | input | NW | Kernel columns |
| cfg_in_h | input | NW | Input rows |
| cfg_in_w | input | NW | Input columns |
| in_base | input | AW | Input tensor base word |
| filt_base | input | AW | Filter tensor base word |
| bias_base | input | AW | Bias vector base word |
| out_base | input | AW | Output region base word (header first) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_done |
| mem_done | input | 1 | One-cycle access completion |

## Verification
The bench targets the padding border. It includes a case where pad exceeds the kernel reach, so whole output pixels see only zeros. A design that clamped or wrapped the border coordinates would fetch real samples, giving wrong sums and a read count above the in-range tap count. Strided cases with non-zero pad catch an offset formed without the two's-complement step or advanced by one instead of stride, since such a design reads the wrong rows. A zero-filter case isolates the bias pass; adding the bias per tap or per input channel shows up as a multiple of b[d]. Random memory latency and a stray start pulse mid-run expose a design that drops its request early, restarts, or pulses done twice.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam int SW = 32;
  typedef logic signed [SW-1:0] sword_t;

  typedef enum logic [4:0] {
    S_IDLE, S_LD1, S_LD2, S_LD3, S_LD4,
    S_HDR_H, S_HDR_W,
    S_COL, S_ROW, S_FCOL, S_FROW, S_CHIN,
    S_RD_Z, S_RD_F, S_RD_X, S_MUL, S_ACC, S_WR_Z,
    S_BR_Z, S_BR_B, S_BADD, S_BW_Z,
    S_FIN
  } seq_st_t;

  // two's-complement negation: invert then add one
  function automatic sword_t neg_of(sword_t v);
    return ~v + sword_t'(1);
  endfunction

  // word offset of an input sample inside its tensor
  function automatic sword_t tap_offset(sword_t ch, sword_t cin, sword_t row,
                                        sword_t hc, sword_t col);
    return ch + cin * row + hc * col;
  endfunction

  // true when the tap coordinate lies inside the stored image
  function automatic logic tap_inside(sword_t row, sword_t col, sword_t h, sword_t w);
    return (row >= 0) && (row < h) && (col >= 0) && (col < w);
  endfunction
endpackage

// File: rtl/conv_cfg_regs.sv
module conv_cfg_regs
  import conv_seq_pkg::*;
#(
  parameter int NW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grp1_en,
  input  logic          grp2_en,
  input  logic          grp3_en,
  input  logic          grp4_en,
  input  logic [NW-1:0] stride_i,
  input  logic [NW-1:0] pad_i,
  input  logic [NW-1:0] out_h_i,
  input  logic [NW-1:0] out_w_i,
  input  logic [NW-1:0] out_ch_i,
  input  logic [NW-1:0] in_ch_i,
  input  logic [NW-1:0] k_h_i,
  input  logic [NW-1:0] k_w_i,
  input  logic [NW-1:0] in_h_i,
  input  logic [NW-1:0] in_w_i,
  input  logic [AW-1:0] in_base_i,
  input  logic [AW-1:0] filt_base_i,
  input  logic [AW-1:0] bias_base_i,
  input  logic [AW-1:0] out_base_i,
  output logic [NW-1:0] stride_q,
  output logic [NW-1:0] pad_q,
  output logic [NW-1:0] out_h_q,
  output logic [NW-1:0] out_w_q,
  output logic [NW-1:0] out_ch_q,
  output logic [NW-1:0] in_ch_q,
  output logic [NW-1:0] k_h_q,
  output logic [NW-1:0] k_w_q,
  output logic [NW-1:0] in_h_q,
  output logic [NW-1:0] in_w_q,
  output logic [AW-1:0] in_base_q,
  output logic [AW-1:0] filt_base_q,
  output logic [AW-1:0] bias_base_q,
  output logic [AW-1:0] out_base_q,
  output sword_t        hc_q
);
  // group 1: geometry of the output walk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stride_q <= '0; pad_q <= '0; out_h_q <= '0; out_w_q <= '0;
    end else if (grp1_en) begin
      stride_q <= stride_i; pad_q <= pad_i; out_h_q <= out_h_i; out_w_q <= out_w_i;
    end
  end

  // group 2: channel counts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_ch_q <= '0; in_ch_q <= '0;
    end else if (grp2_en) begin
      out_ch_q <= out_ch_i; in_ch_q <= in_ch_i;
    end
  end

  // group 3: kernel and image extents
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_h_q <= '0; k_w_q <= '0; in_h_q <= '0; in_w_q <= '0;
    end else if (grp3_en) begin
      k_h_q <= k_h_i; k_w_q <= k_w_i; in_h_q <= in_h_i; in_w_q <= in_w_i;
    end
  end

  // group 4: region bases plus the column stride of the input tensor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_base_q <= '0; filt_base_q <= '0; bias_base_q <= '0; out_base_q <= '0;
      hc_q <= '0;
    end else if (grp4_en) begin
      in_base_q   <= in_base_i;
      filt_base_q <= filt_base_i;
      bias_base_q <= bias_base_i;
      out_base_q  <= out_base_i;
      hc_q        <= sword_t'(in_h_q) * sword_t'(in_ch_q);
    end
  end
endmodule

// File: rtl/conv_addr_unit.sv
module conv_addr_unit
  import conv_seq_pkg::*;
#(
  parameter int NW = 8,
  parameter int AW = 16
) (
  input  logic [AW-1:0] x_base,
  input  logic [NW-1:0] cin,
  input  logic [NW-1:0] hin,
  input  logic [NW-1:0] win,
  input  sword_t        hc,
  input  logic [NW-1:0] gamma,
  input  logic [NW-1:0] alpha,
  input  logic [NW-1:0] beta,
  input  sword_t        row0,
  input  sword_t        col0,
  output logic [AW-1:0] x_addr,
  output logic          x_pad
);
  sword_t row, col, off;

  always_comb begin
    row    = row0 + sword_t'(alpha);
    col    = col0 + sword_t'(beta);
    off    = tap_offset(sword_t'(gamma), sword_t'(cin), row, hc, col);
    x_addr = x_base + AW'(off);
    x_pad  = !tap_inside(row, col, sword_t'(hin), sword_t'(win));
  end
endmodule

// File: rtl/conv_mac_unit.sv
module conv_mac_unit #(
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        rdata,
  input  logic                 ld_acc,
  input  logic                 ld_op,
  input  logic                 ld_x,
  input  logic                 zero_x,
  input  logic                 mul_en,
  input  logic                 add_en,
  input  logic                 add_bias,
  output logic signed [DW-1:0] sum
);
  logic signed [DW-1:0] acc, opb, opx, prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; opb <= '0; opx <= '0; prod <= '0; sum <= '0;
    end else begin
      if (ld_acc) acc <= $signed(rdata);
      if (ld_op)  opb <= $signed(rdata);
      if (zero_x)    opx <= '0;
      else if (ld_x) opx <= $signed(rdata);
      if (mul_en) prod <= opb * opx;
      if (add_en) sum  <= acc + (add_bias ? opb : prod);
    end
  end
endmodule

// File: rtl/conv_fwd_seq.sv
module conv_fwd_seq
  import conv_seq_pkg::*;
#(
  parameter int NW = 8,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] cfg_stride,
  input  logic [NW-1:0] cfg_pad,
  input  logic [NW-1:0] cfg_out_h,
  input  logic [NW-1:0] cfg_out_w,
  input  logic [NW-1:0] cfg_out_ch,
  input  logic [NW-1:0] cfg_in_ch,
  input  logic [NW-1:0] cfg_k_h,
  input  logic [NW-1:0] cfg_k_w,
  input  logic [NW-1:0] cfg_in_h,
  input  logic [NW-1:0] cfg_in_w,
  input  logic [AW-1:0] in_base,
  input  logic [AW-1:0] filt_base,
  input  logic [AW-1:0] bias_base,
  input  logic [AW-1:0] out_base,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_done
);
  seq_st_t state;

  logic [NW-1:0] stride_q, pad_q, out_h_q, out_w_q, out_ch_q, in_ch_q;
  logic [NW-1:0] k_h_q, k_w_q, in_h_q, in_w_q;
  logic [AW-1:0] in_base_q, filt_base_q, bias_base_q, out_base_q;
  sword_t        hc_q;

  // loop counters: j col, i row, fb kernel col, fa kernel row, g in-ch, d out-ch
  logic [NW-1:0] j, i, fb, fa, g, d;
  sword_t        jx, ix;
  logic [AW-1:0] zpix, fptr, xaddr_q;
  logic          xpad_q;
  logic [AW-1:0] x_addr;
  logic          x_pad;
  logic signed [DW-1:0] sum;

  // named internal events
  logic   col_end, row_end, fcol_end, frow_end, chin_end, last_ch, x_step;
  sword_t pad_s, stride_s;

  assign pad_s    = sword_t'(pad_q);
  assign stride_s = sword_t'(stride_q);
  assign col_end  = (j  == out_w_q);
  assign row_end  = (i  == out_h_q);
  assign fcol_end = (fb == k_w_q);
  assign frow_end = (fa == k_h_q);
  assign chin_end = (g  == in_ch_q);
  assign last_ch  = (d  == out_ch_q - NW'(1));
  assign x_step   = xpad_q || mem_done;

  conv_cfg_regs #(.NW(NW), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .grp1_en(state == S_LD1), .grp2_en(state == S_LD2),
    .grp3_en(state == S_LD3), .grp4_en(state == S_LD4),
    .stride_i(cfg_stride), .pad_i(cfg_pad), .out_h_i(cfg_out_h), .out_w_i(cfg_out_w),
    .out_ch_i(cfg_out_ch), .in_ch_i(cfg_in_ch), .k_h_i(cfg_k_h), .k_w_i(cfg_k_w),
    .in_h_i(cfg_in_h), .in_w_i(cfg_in_w),
    .in_base_i(in_base), .filt_base_i(filt_base), .bias_base_i(bias_base),
    .out_base_i(out_base),
    .stride_q(stride_q), .pad_q(pad_q), .out_h_q(out_h_q), .out_w_q(out_w_q),
    .out_ch_q(out_ch_q), .in_ch_q(in_ch_q), .k_h_q(k_h_q), .k_w_q(k_w_q),
    .in_h_q(in_h_q), .in_w_q(in_w_q),
    .in_base_q(in_base_q), .filt_base_q(filt_base_q), .bias_base_q(bias_base_q),
    .out_base_q(out_base_q), .hc_q(hc_q)
  );

  conv_addr_unit #(.NW(NW), .AW(AW)) u_addr (
    .x_base(in_base_q), .cin(in_ch_q), .hin(in_h_q), .win(in_w_q), .hc(hc_q),
    .gamma(g), .alpha(fa), .beta(fb), .row0(ix), .col0(jx),
    .x_addr(x_addr), .x_pad(x_pad)
  );

  conv_mac_unit #(.DW(DW)) u_mac (
    .clk(clk), .rst_n(rst_n), .rdata(mem_rdata),
    .ld_acc((state == S_RD_Z || state == S_BR_Z) && mem_done),
    .ld_op((state == S_RD_F || state == S_BR_B) && mem_done),
    .ld_x(state == S_RD_X && !xpad_q && mem_done),
    .zero_x(state == S_RD_X && xpad_q),
    .mul_en(state == S_MUL),
    .add_en(state == S_ACC || state == S_BADD),
    .add_bias(state == S_BADD),
    .sum(sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      j <= '0; i <= '0; fb <= '0; fa <= '0; g <= '0; d <= '0;
      jx <= '0; ix <= '0; zpix <= '0; fptr <= '0; xaddr_q <= '0; xpad_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) state <= S_LD1;
        S_LD1:  state <= S_LD2;
        S_LD2:  state <= S_LD3;
        S_LD3:  state <= S_LD4;
        S_LD4: begin
          zpix  <= out_base;
          j     <= '0;
          jx    <= neg_of(pad_s);
          state <= S_HDR_H;
        end
        S_HDR_H: if (mem_done) begin zpix <= zpix + AW'(1); state <= S_HDR_W; end
        S_HDR_W: if (mem_done) begin zpix <= zpix + AW'(1); state <= S_COL;   end
        S_COL: begin
          if (col_end) state <= S_FIN;
          else begin i <= '0; ix <= neg_of(pad_s); state <= S_ROW; end
        end
        S_ROW: begin
          if (row_end) begin j <= j + NW'(1); jx <= jx + stride_s; state <= S_COL; end
          else begin fb <= '0; fptr <= filt_base_q; state <= S_FCOL; end
        end
        S_FCOL: begin
          if (fcol_end) begin d <= '0; state <= S_BR_Z; end
          else begin fa <= '0; state <= S_FROW; end
        end
        S_FROW: begin
          if (frow_end) begin fb <= fb + NW'(1); state <= S_FCOL; end
          else begin g <= '0; state <= S_CHIN; end
        end
        S_CHIN: begin
          if (chin_end) begin fa <= fa + NW'(1); state <= S_FROW; end
          else begin
            d <= '0; xaddr_q <= x_addr; xpad_q <= x_pad; state <= S_RD_Z;
          end
        end
        S_RD_Z: if (mem_done) state <= S_RD_F;
        S_RD_F: if (mem_done) state <= S_RD_X;
        S_RD_X: if (x_step)   state <= S_MUL;
        S_MUL:  state <= S_ACC;
        S_ACC:  state <= S_WR_Z;
        S_WR_Z: if (mem_done) begin
          fptr <= fptr + AW'(1);
          if (last_ch) begin g <= g + NW'(1); state <= S_CHIN; end
          else begin d <= d + NW'(1); state <= S_RD_Z; end
        end
        S_BR_Z: if (mem_done) state <= S_BR_B;
        S_BR_B: if (mem_done) state <= S_BADD;
        S_BADD: state <= S_BW_Z;
        S_BW_Z: if (mem_done) begin
          if (last_ch) begin
            zpix  <= zpix + AW'(out_ch_q);
            i     <= i + NW'(1);
            ix    <= ix + stride_s;
            state <= S_ROW;
          end else begin
            d <= d + NW'(1); state <= S_BR_Z;
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // memory port steering
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = sum;
    case (state)
      S_HDR_H: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = zpix; mem_wdata = DW'(out_h_q); end
      S_HDR_W: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = zpix; mem_wdata = DW'(out_w_q); end
      S_RD_Z, S_BR_Z: begin mem_req = 1'b1; mem_addr = zpix + AW'(d); end
      S_WR_Z, S_BW_Z: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = zpix + AW'(d); end
      S_RD_F: begin mem_req = 1'b1; mem_addr = fptr; end
      S_RD_X: begin mem_req = !xpad_q; mem_addr = xaddr_q; end
      S_BR_B: begin mem_req = 1'b1; mem_addr = bias_base_q + AW'(d); end
      default: ;
    endcase
  end

  assign busy = (state != S_IDLE) && (state != S_FIN);
  assign done = (state == S_FIN);

  // R6: an outstanding request does not move until it completes
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_done |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R7: completion pulse lasts one cycle and is seen with busy low
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2: a start during a run does not restart the capture sequence
  a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> state != S_LD1);

  // R3: the first access after capture writes output height to the region base
  a_r3_header_first: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_LD4 |=> mem_req && mem_we && mem_addr == out_base_q && mem_wdata == DW'(out_h_q));

  // R5: a sample fetch always lands inside the stored input tensor
  a_r5_tap_in_tensor: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_RD_X && mem_req |->
      (mem_addr >= in_base_q) &&
      (sword_t'(mem_addr - in_base_q) < hc_q * sword_t'(in_w_q)));

  // R10: writes never fall below the output region
  a_r10_write_region: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr >= out_base_q);
endmodule

// File: tb/sim_conv_fwd_seq.sv
module sim_conv_fwd_seq;
  localparam int CLK_P = 10;
  localparam int MEMW  = 4096;
  localparam int XB = 0, FB = 1024, BB = 2048, OB = 3072;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] c_stride, c_pad, c_oh, c_ow, c_oc, c_ic, c_kh, c_kw, c_ih, c_iw;
  logic busy, done, mem_req, mem_we, mem_done;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  int mem  [0:MEMW-1];
  int snap [0:MEMW-1];
  int tests = 0, fails = 0, cyc = 0;
  bit timed_out = 1'b0;
  int done_cnt, xreads, wr_cnt, wr_bad, hs_err, lat;
  logic hold_req, hold_we;
  logic [15:0] hold_addr;
  logic [31:0] hold_wd;

  always #(CLK_P/2) clk = ~clk;

  conv_fwd_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_stride(c_stride), .cfg_pad(c_pad), .cfg_out_h(c_oh), .cfg_out_w(c_ow),
    .cfg_out_ch(c_oc), .cfg_in_ch(c_ic), .cfg_k_h(c_kh), .cfg_k_w(c_kw),
    .cfg_in_h(c_ih), .cfg_in_w(c_iw),
    .in_base(16'(XB)), .filt_base(16'(FB)), .bias_base(16'(BB)), .out_base(16'(OB)),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
  );

  // memory model with random latency and handshake monitor
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) timed_out = 1'b1;
    if (!rst_n) begin
      mem_done <= 1'b0; hold_req <= 1'b0; lat <= 0; mem_rdata <= '0;
    end else begin
      if (done) done_cnt++;
      if (hold_req && (!mem_req || mem_addr != hold_addr || mem_we != hold_we ||
                       (mem_we && mem_wdata != hold_wd))) hs_err++;
      hold_req  <= mem_req && !mem_done;
      hold_addr <= mem_addr;
      hold_we   <= mem_we;
      hold_wd   <= mem_wdata;
      mem_done  <= 1'b0;
      if (mem_req && !mem_done) begin
        if (lat == 0) begin
          mem_done <= 1'b1;
          lat <= $urandom_range(0, 2);
          if (mem_we) begin
            wr_cnt++;
            if (mem_addr < OB || mem_addr >= OB + 1024) wr_bad++;
            mem[mem_addr[11:0]] = mem_wdata;
          end else begin
            if (mem_addr < FB) xreads++;
            mem_rdata <= mem[mem_addr[11:0]];
          end
        end else lat <= lat - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input int st, input int pd, input int ih, input int iw,
                          input int ic, input int oc, input int kh, input int kw,
                          input bit zero_f, input bit poke, input string tag);
    int oh, ow, nbad, bad_act, bad_exp, exp_x, acc, r, c;
    oh = (ih + 2*pd - kh) / st + 1;
    ow = (iw + 2*pd - kw) / st + 1;
    for (int k = 0; k < ih*iw*ic; k++) mem[XB+k] = int'($urandom_range(0, 15)) - 8;
    for (int k = 0; k < oc*ic*kh*kw; k++) mem[FB+k] = zero_f ? 0 : int'($urandom_range(0, 7)) - 4;
    for (int k = 0; k < oc; k++) mem[BB+k] = int'($urandom_range(0, 100)) - 50;
    for (int k = 0; k < 2 + oh*ow*oc; k++) mem[OB+k] = int'($urandom_range(0, 200)) - 100;
    for (int k = 0; k < MEMW; k++) snap[k] = mem[k];
    @(negedge clk);
    c_stride = 8'(st); c_pad = 8'(pd); c_oh = 8'(oh); c_ow = 8'(ow);
    c_oc = 8'(oc); c_ic = 8'(ic); c_kh = 8'(kh); c_kw = 8'(kw); c_ih = 8'(ih); c_iw = 8'(iw);
    done_cnt = 0; xreads = 0; wr_cnt = 0; wr_bad = 0; hs_err = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7", "busy after start", int'(busy), 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      chk(busy == 1'b1, "R2", "busy before stray start", int'(busy), 1);
      start = 1'b1; c_oh = c_oh + 8'd3; c_oc = c_oc + 8'd1; c_pad = c_pad + 8'd1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == 0 && !timed_out) @(negedge clk);
    repeat (4) @(negedge clk);

    // reference model
    nbad = 0; bad_act = 0; bad_exp = 0; exp_x = 0;
    for (int j = 0; j < ow; j++)
      for (int i = 0; i < oh; i++)
        for (int d = 0; d < oc; d++) begin
          acc = snap[OB + 2 + d + oc*(i + oh*j)];
          for (int b = 0; b < kw; b++)
            for (int a = 0; a < kh; a++)
              for (int g = 0; g < ic; g++) begin
                r = i*st - pd + a;
                c = j*st - pd + b;
                if (r >= 0 && r < ih && c >= 0 && c < iw) begin
                  acc += snap[FB + d + oc*(g + ic*(a + kh*b))] * snap[XB + g + ic*r + ih*ic*c];
                  exp_x++;
                end
              end
          acc += snap[BB + d];
          if (mem[OB + 2 + d + oc*(i + oh*j)] != acc) begin
            if (nbad == 0) begin bad_act = mem[OB + 2 + d + oc*(i + oh*j)]; bad_exp = acc; end
            nbad++;
          end
        end
    chk(mem[OB] == oh, "R3", "header height", mem[OB], oh);
    chk(mem[OB+1] == ow, "R3", "header width", mem[OB+1], ow);
    chk(nbad == 0, tag, "output value", bad_act, bad_exp);
    chk(xreads == exp_x, "R5", "input read count", xreads, exp_x);
    chk(wr_cnt == 2 + oh*ow*oc*(kh*kw*ic + 1), "R10", "write count", wr_cnt,
        2 + oh*ow*oc*(kh*kw*ic + 1));
    chk(wr_bad == 0, "R10", "writes outside output region", wr_bad, 0);
    chk(hs_err == 0, "R6", "request changed before done", hs_err, 0);
    chk(done_cnt == 1, poke ? "R2" : "R7", "done pulses", done_cnt, 1);
    chk(busy == 1'b0, "R7", "busy after done", int'(busy), 0);
  endtask

  initial begin
    int ih, iw, pd, st, kh, kw;
    void'($urandom(32'd4242));
    for (int k = 0; k < MEMW; k++) mem[k] = 0;
    {c_stride, c_pad, c_oh, c_ow, c_oc, c_ic, c_kh, c_kw, c_ih, c_iw} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", int'(mem_req), 0);

    run_case(1, 0, 3, 3, 1, 1, 2, 2, 1'b0, 1'b0, "R4");
    run_case(2, 1, 4, 5, 2, 2, 3, 3, 1'b0, 1'b0, "R8");
    run_case(1, 1, 3, 3, 1, 3, 3, 3, 1'b1, 1'b0, "R9");
    run_case(1, 2, 2, 2, 1, 2, 1, 1, 1'b0, 1'b0, "R5");
    run_case(2, 1, 4, 5, 2, 2, 3, 3, 1'b0, 1'b1, "R2");
    for (int n = 0; n < 5; n++) begin
      ih = $urandom_range(2, 4); iw = $urandom_range(2, 4);
      pd = $urandom_range(0, 1); st = $urandom_range(1, 2);
      kh = $urandom_range(1, (ih + 2*pd) < 3 ? ih + 2*pd : 3);
      kw = $urandom_range(1, (iw + 2*pd) < 3 ? iw + 2*pd : 3);
      run_case(st, pd, ih, iw, $urandom_range(1, 2), $urandom_range(1, 2), kh, kw,
               1'b0, 1'b0, "R4");
    end

    if (timed_out) begin
      tests++; fails++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, 190000);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule